// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block holds the pending-event and interrupt-mask state of a USB peripheral controller behind a byte-wide register bus. The endpoint, DMA, start-of-frame and bus-reset logic each send single-cycle pulses. Each pulse sets a sticky pending bit. Software reads the pending register and acknowledges events by writing ones to it. A separate mask register chooses which pending bits drive the single active-high interrupt request. The mask only gates that request and never alters the pending bits.

The top bit of both registers does not store anything. It mirrors the live busy level of the DMA engine. It is read-only and never raises the interrupt.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mask register and the pending bits are all zero and `irq_out` is low.
- R2: A one on `evt_pulse[i]` sets pending bit i on the next clock edge, and the bit stays set until it is acknowledged. The bit map is: bits 0..3 endpoint 0..3 done, bit 4 DMA done, bit 5 start-of-frame seen, bit 6 bus reset seen.
- R3: A write to address 0x0D clears every pending bit whose write-data bit is one. Pending bits whose write-data bit is zero are left unchanged.
- R4: If an event pulse and an acknowledge of the same bit fall in the same cycle, the bit is left set.
- R5: A write to address 0x06 stores write-data bits 6:0 as the mask, and these read back at 0x06. The write never changes any pending bit.
- R6: `irq_out` is high exactly when some bit of (pending AND mask) was one at the previous clock edge, so it lags a register change by one cycle.
- R7: Bit 7 of a read at either 0x06 or 0x0D returns the live `dma_busy` level. Writes to bit 7 at either address have no effect, and `dma_busy` never drives `irq_out`.
- R8: `bus_rdata` is combinational. With `bus_rd` high it returns the addressed register; with `bus_rd` low, or at any other address, it is zero. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| evt_pulse | input | 7 | Single-cycle event pulses, one per pending bit |
| dma_busy | input | 1 | Live DMA transfer-in-progress level |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, seven event bits, and the mask and pending registers at 0x06 and 0x0D. At this width every one of the 128 mask values can be swept. For each mask the bench injects a different pending pattern, which covers the output gating and its one-cycle lag across the whole mask space. An 8-bit address also makes a sweep of all 254 unmapped addresses cheap, for both reads and writes. Per-bit sweeps cover acknowledge and the same-cycle event-versus-acknowledge case on every bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Which register the current bus cycle selects, split by direction.
  typedef struct packed {
    logic wr_mask;
    logic wr_pend;
    logic rd_mask;
    logic rd_pend;
  } reg_sel_t;

  // Build a read word: stored bits at the bottom, live flag in the top bit.
  function automatic logic [63:0] pack_read_word(input logic [63:0] stored,
                                                 input int unsigned n_bits,
                                                 input int unsigned word_w,
                                                 input logic live_flag);
    logic [63:0] w;
    w = '0;
    for (int unsigned k = 0; k < n_bits; k++) begin
      w[k] = stored[k];
    end
    w[word_w-1] = live_flag;
    return w;
  endfunction

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    MASK_ADDR = 8'h06,
  parameter logic [ADDR_W-1:0]    PEND_ADDR = 8'h0D
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output reg_sel_t          sel
);

  logic hit_mask;
  logic hit_pend;

  always_comb begin
    hit_mask    = (bus_addr == MASK_ADDR);
    hit_pend    = (bus_addr == PEND_ADDR);
    sel.wr_mask = bus_wr & hit_mask;
    sel.wr_pend = bus_wr & hit_pend;
    sel.rd_mask = bus_rd & hit_mask;
    sel.rd_pend = bus_rd & hit_pend;
  end

endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic             ack_en,
  input  logic [N_EVT-1:0] ack_bits,
  output logic [N_EVT-1:0] pend
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_cell
    logic cell_q;
    logic cell_d;
    logic cell_ce;

    // A new event wins over an acknowledge of the same bit.
    always_comb begin
      cell_ce = evt_pulse[i] | (ack_en & ack_bits[i]);
      cell_d  = evt_pulse[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 1'b0;
      end else if (cell_ce) begin
        cell_q <= cell_d;
      end
    end

    assign pend[i] = cell_q;
  end

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int unsigned N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] mask
);

  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] mask_d;

  always_comb begin
    mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
  parameter int unsigned N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] pend,
  input  logic [N_EVT-1:0] mask,
  output logic             irq
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(pend & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       N_EVT     = 7,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h06,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic              dma_busy,
  output logic              irq_out
);

  localparam int unsigned RST_STAGES = 2;

  logic             rst_sync_n;
  reg_sel_t         sel;
  logic [N_EVT-1:0] pend_q;
  logic [N_EVT-1:0] mask_q;
  logic [63:0]      mask_word;
  logic [63:0]      pend_word;

  evt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evt_bus_decode #(
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (MASK_ADDR),
    .PEND_ADDR (PEND_ADDR)
  ) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .sel      (sel)
  );

  evt_pend_bank #(.N_EVT(N_EVT)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_pulse (evt_pulse),
    .ack_en    (sel.wr_pend),
    .ack_bits  (bus_wdata[N_EVT-1:0]),
    .pend      (pend_q)
  );

  evt_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (sel.wr_mask),
    .wdata (bus_wdata[N_EVT-1:0]),
    .mask  (mask_q)
  );

  evt_irq_reduce #(.N_EVT(N_EVT)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pend  (pend_q),
    .mask  (mask_q),
    .irq   (irq_out)
  );

  always_comb begin
    mask_word = pack_read_word(64'(mask_q), N_EVT, DATA_W, dma_busy);
    pend_word = pack_read_word(64'(pend_q), N_EVT, DATA_W, dma_busy);
    bus_rdata = '0;
    if (sel.rd_mask) begin
      bus_rdata = mask_word[DATA_W-1:0];
    end else if (sel.rd_pend) begin
      bus_rdata = pend_word[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       N_EVT     = 7,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h06,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h0D
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_EVT-1:0]  evt_pulse,
  input logic              dma_busy,
  input logic              irq_out,
  input logic [N_EVT-1:0]  pend_q,
  input logic [N_EVT-1:0]  mask_q
);

  logic             mapped;
  logic [N_EVT-1:0] ack_now;

  always_comb begin
    mapped  = (bus_addr == MASK_ADDR) || (bus_addr == PEND_ADDR);
    ack_now = (bus_wr && bus_addr == PEND_ADDR) ? bus_wdata[N_EVT-1:0] : '0;
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (pend_q == '0 && mask_q == '0 && !irq_out));

  // R2 and R4: a pulse always lands, even against an acknowledge
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|evt_pulse) |=> ((pend_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ack_now) |=> ((pend_q & $past(ack_now & ~evt_pulse)) == '0));

  p_unacked_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~ack_now)) == $past(pend_q & ~ack_now)));

  p_mask_no_touch_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == MASK_ADDR && evt_pulse == '0) |=> (pend_q == $past(pend_q)));

  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_out == (|$past(pend_q & mask_q))));

  p_busy_live_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && mapped) |-> (bus_rdata[DATA_W-1] == dma_busy));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_rd || !mapped) |-> (bus_rdata == '0));

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .N_EVT     (N_EVT),
  .MASK_ADDR (MASK_ADDR),
  .PEND_ADDR (PEND_ADDR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .evt_pulse  (evt_pulse),
  .dma_busy   (dma_busy),
  .irq_out    (irq_out),
  .pend_q     (pend_q),
  .mask_q     (mask_q)
);

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;

  localparam logic [7:0] A_MASK = 8'h06;
  localparam logic [7:0] A_PEND = 8'h0D;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [6:0] evt_pulse;
  logic       dma_busy;
  logic       irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .dma_busy  (dma_busy),
    .irq_out   (irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    d        = bus_rdata;
    bus_rd   = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    evt_pulse = '0;
    dma_busy  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_read(A_MASK, rd); chk("R1 mask after reset", rd, 8'h00);
    bus_read(A_PEND, rd); chk("R1 pending after reset", rd, 8'h00);
    chk("R1 irq after reset", irq_out, 0);

    // R2 R5 R6: sweep all mask values against varied pending patterns
    for (int e = 0; e < 128; e++) begin
      logic [6:0] m;
      logic [6:0] s;
      m = 7'(e);
      s = 7'((e * 37 + 11) % 128);
      bus_write(A_MASK, {1'b0, m});
      bus_read(A_MASK, rd); chk("R5 mask readback", rd, {1'b0, m});
      @(negedge clk);
      evt_pulse = s;
      @(negedge clk);
      evt_pulse = '0;
      chk("R6 irq not early", irq_out, 0);
      @(negedge clk);
      chk("R6 irq one cycle later", irq_out, 32'(|(s & m)));
      bus_read(A_PEND, rd); chk("R2 pending sticky", rd, {1'b0, s});
      bus_write(A_MASK, {1'b0, ~m});
      bus_read(A_PEND, rd); chk("R5 mask write keeps pending", rd, {1'b0, s});
      chk("R6 irq with new mask", irq_out, 32'(|(s & ~m)));
      bus_write(A_PEND, 8'h7F);
      bus_read(A_PEND, rd); chk("R3 clear all", rd, 8'h00);
      chk("R6 irq drops after clear", irq_out, 0);
    end

    // R3: per-bit acknowledge, zeros leave bits alone
    bus_write(A_MASK, 8'h7F);
    pulse(7'h7F);
    bus_write(A_PEND, 8'h00);
    bus_read(A_PEND, rd); chk("R3 zero write no effect", rd, 8'h7F);
    for (int b = 0; b < 7; b++) begin
      bus_write(A_PEND, 8'(1 << b));
      bus_read(A_PEND, rd);
      chk("R3 single-bit ack", rd, 32'(8'h7F & ~8'((2 << b) - 1)));
    end
    @(negedge clk);
    chk("R6 irq low once all acked", irq_out, 0);

    // R4: event and acknowledge of the same bit in one cycle
    for (int b = 0; b < 7; b++) begin
      pulse(7'h7F);
      @(negedge clk);
      evt_pulse = 7'(1 << b);
      bus_addr  = A_PEND;
      bus_wdata = 8'h7F;
      bus_wr    = 1'b1;
      @(negedge clk);
      evt_pulse = '0;
      bus_wr    = 1'b0;
      bus_read(A_PEND, rd); chk("R4 event beats ack", rd, 32'(1 << b));
      bus_write(A_PEND, 8'h7F);
    end

    // R7: live DMA busy flag
    bus_write(A_MASK, 8'h00);
    dma_busy = 1'b1;
    bus_read(A_MASK, rd); chk("R7 busy at mask addr", rd, 8'h80);
    bus_read(A_PEND, rd); chk("R7 busy at pending addr", rd, 8'h80);
    bus_write(A_MASK, 8'hFF);
    repeat (2) @(negedge clk);
    chk("R7 busy never raises irq", irq_out, 0);
    bus_write(A_MASK, 8'h80);
    bus_read(A_MASK, rd); chk("R7 bit7 mask write ignored", rd, 8'h80);
    pulse(7'h7F);
    bus_write(A_PEND, 8'h80);
    bus_read(A_PEND, rd); chk("R7 bit7 ack write ignored", rd, 8'hFF);
    dma_busy = 1'b0;
    bus_read(A_PEND, rd); chk("R7 busy falls live", rd, 8'h7F);
    bus_write(A_MASK, 8'h7F);

    // R8: idle read, unmapped reads and writes
    @(negedge clk);
    bus_addr = A_PEND;
    bus_rd   = 1'b0;
    #1;
    chk("R8 no strobe reads zero", bus_rdata, 0);
    for (int a = 0; a < 256; a++) begin
      if (8'(a) != A_MASK && 8'(a) != A_PEND) begin
        bus_read(8'(a), rd);
        chk("R8 unmapped read zero", rd, 0);
        bus_write(8'(a), 8'hFF);
      end
    end
    bus_read(A_PEND, rd); chk("R8 unmapped writes keep pending", rd, 8'h7F);
    bus_read(A_MASK, rd); chk("R8 unmapped writes keep mask", rd, 8'h7F);
    chk("R6 irq with all pending", irq_out, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule